// File: doc/BRIEF.md
# Global Free-Running Counter with Periodic Comparator

This block is a memory-mapped system timer. A 64-bit counter advances by one on every clock while its run bit is set. Software loads it as two 32-bit halves and reads it back live, with no snapshot. Software must read the high half, then the low half, then the high half again to catch a carry between the two reads. One 64-bit comparator watches the counter. When the comparator is enabled and the count equals the compare value, a sticky interrupt status bit is raised. The interrupt line is that status bit gated by an enable bit.

The comparator has an auto-increment mode. After each match it adds a programmed 32-bit step to its own compare value, so a running counter produces an event every step cycles and software does not have to rearm it.

Every write to the counter halves, the compare halves, the step register or the control register raises a sticky acknowledge bit in one of two write-status registers. Software polls that bit to learn that the write has landed, then clears it by writing a one to it. The bus is a simple single-cycle register port: a write is accepted on the clock edge where select and write are both high, and read data follows the address combinationally.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the count, the control register, the interrupt status, the interrupt enable and both write-status registers read 0, and irq_o is low.
- R2: While control bit 8 (run) is 1, the count grows by exactly one per clock. While it is 0, the count holds.
- R3: A write to 0x100 replaces count bits 31:0 and a write to 0x104 replaces bits 63:32. The written value takes the place of that cycle's increment. Reads of 0x100/0x104 return the live count.
- R4: With control bit 0 (compare enable) set, a count equal to the 64-bit compare value (0x200 low, 0x204 high) sets interrupt status bit 0 (0x244) on the next edge. With bit 0 clear, no status is set.
- R5: With control bit 1 (auto-increment) also set, each match adds the 32-bit step at 0x208 to the compare value. This gives a match every step cycles. Without bit 1, the compare value stays unchanged after a match.
- R6: Writing 1 to bit 0 of 0x244 clears the interrupt status, and writing 0 leaves it as it is. A match in the same cycle as the clear keeps it set.
- R7: irq_o is high exactly when the interrupt status is 1 and enable bit 0 of 0x248 is 1.
- R8: One cycle after an accepted write, the write-status register at 0x24C shows bit 0 for the compare low half, bit 1 for the compare high half, bit 2 for the step and bit 16 for control. The register at 0x110 shows bit 0 for the count low half and bit 1 for the count high half.
- R9: Write-status bits stay set until a 1 is written to their own position in their own register. Writing 0 changes nothing.
- R10: Control reads back only bits 8, 1 and 0. Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write when high together with select |
| bus_addr_i | input | ADDR_W (12) | Byte address of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Comparator interrupt |

## Verification
The comparator is exercised with a single match far from the preload, which checks the exact cycle of the status edge and the irq gating. A second run with compare enable off tells an ungated match apart from a gated one. An auto-increment run with a step of 7 shows that the compare value is rewritten after a match and that the second event lands exactly one step later. A stopped counter parked on the compare value separates "set wins over clear" from a plain clear. The counter itself is driven across a 32-bit carry and overwritten while running, which separates a live half-write from an increment.

// File: rtl/stt_pkg.sv
// Shared constants and types of the system tick timer.
// Assumes DATA_W >= 17 so that the control acknowledge position fits.
package stt_pkg;

    // Register byte offsets, decoded by software drivers.
    localparam int unsigned OFS_CNT_LO = 'h100;
    localparam int unsigned OFS_CNT_HI = 'h104;
    localparam int unsigned OFS_CNT_WS = 'h110;
    localparam int unsigned OFS_CMP_LO = 'h200;
    localparam int unsigned OFS_CMP_HI = 'h204;
    localparam int unsigned OFS_STEP   = 'h208;
    localparam int unsigned OFS_CTRL   = 'h240;
    localparam int unsigned OFS_ISTAT  = 'h244;
    localparam int unsigned OFS_IEN    = 'h248;
    localparam int unsigned OFS_GWS    = 'h24C;

    // Control bit positions.
    localparam int CTL_CMPEN_BIT = 0;
    localparam int CTL_AUTO_BIT  = 1;
    localparam int CTL_RUN_BIT   = 8;

    // Acknowledge bit counts.
    localparam int CWS_N = 2;   // count low, count high
    localparam int GWS_N = 4;   // compare low, compare high, step, control

    // Bit position of acknowledge index i in the global write-status register.
    function automatic int gws_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 16;
        endcase
    endfunction

    typedef enum logic [3:0] {
        RID_NONE,
        RID_CNT_LO,
        RID_CNT_HI,
        RID_CNT_WS,
        RID_CMP_LO,
        RID_CMP_HI,
        RID_STEP,
        RID_CTRL,
        RID_ISTAT,
        RID_IEN,
        RID_GWS
    } reg_id_e;

endpackage

// File: rtl/stt_decode.sv
// Address decoder: maps a byte address onto a register identifier.
// Assumes exact-match decoding; every other address maps to RID_NONE.
module stt_decode
    import stt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_id_e           rid_o
);

    // Compare the address against each register offset.
    always_comb begin
        if      (addr_i == ADDR_W'(OFS_CNT_LO)) rid_o = RID_CNT_LO;
        else if (addr_i == ADDR_W'(OFS_CNT_HI)) rid_o = RID_CNT_HI;
        else if (addr_i == ADDR_W'(OFS_CNT_WS)) rid_o = RID_CNT_WS;
        else if (addr_i == ADDR_W'(OFS_CMP_LO)) rid_o = RID_CMP_LO;
        else if (addr_i == ADDR_W'(OFS_CMP_HI)) rid_o = RID_CMP_HI;
        else if (addr_i == ADDR_W'(OFS_STEP))   rid_o = RID_STEP;
        else if (addr_i == ADDR_W'(OFS_CTRL))   rid_o = RID_CTRL;
        else if (addr_i == ADDR_W'(OFS_ISTAT))  rid_o = RID_ISTAT;
        else if (addr_i == ADDR_W'(OFS_IEN))    rid_o = RID_IEN;
        else if (addr_i == ADDR_W'(OFS_GWS))    rid_o = RID_GWS;
        else                                    rid_o = RID_NONE;
    end

endmodule

// File: rtl/stt_counter.sv
// Free-running counter of 2*DATA_W bits, preloadable per DATA_W half.
// Assumes at most one half is written per cycle; a write replaces the
// increment of that cycle.
module stt_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [2*DATA_W-1:0] count_o
);

    localparam int NHALF = 2;
    localparam int CNT_W = NHALF * DATA_W;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic [NHALF-1:0] wr_half;

    assign wr_half = {wr_hi_i, wr_lo_i};

    // Next count: a half write wins over the increment.
    always_comb begin
        if (|wr_half) begin
            count_d = count_q;
            for (int h = 0; h < NHALF; h++) begin
                if (wr_half[h]) count_d[h*DATA_W +: DATA_W] = wdata_i;
            end
        end else if (run_i) begin
            count_d = count_q + CNT_W'(1);
        end else begin
            count_d = count_q;
        end
    end

    // Count register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign count_o = count_q;

endmodule

// File: rtl/stt_compare.sv
// Comparator with optional auto-increment and a sticky match status.
// Assumes software writes of the compare halves win over auto-increment
// and that a match wins over a status clear in the same cycle.
module stt_compare #(
    parameter int DATA_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_i,
    input  logic                auto_i,
    input  logic [2*DATA_W-1:0] count_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic                wr_step_i,
    input  logic                clr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [2*DATA_W-1:0] cmp_o,
    output logic [DATA_W-1:0]   step_o,
    output logic                stat_o
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cmp_q;
    logic [DATA_W-1:0] step_q;
    logic              stat_q;
    logic              hit;

    assign hit = en_i && (count_i == cmp_q);

    // Compare value: software halves first, then self-advance on a hit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q <= '0;
        end else if (wr_lo_i) begin
            cmp_q[DATA_W-1:0] <= wdata_i;
        end else if (wr_hi_i) begin
            cmp_q[CNT_W-1:DATA_W] <= wdata_i;
        end else if (hit && auto_i) begin
            cmp_q <= cmp_q + CNT_W'(step_q);
        end
    end

    // Step register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        step_q <= '0;
        else if (wr_step_i) step_q <= wdata_i;
    end

    // Sticky match status.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    stat_q <= 1'b0;
        else if (hit)   stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
    end

    assign cmp_o  = cmp_q;
    assign step_o = step_q;
    assign stat_o = stat_q;

endmodule

// File: rtl/stt_wstat.sv
// Bank of sticky acknowledge bits, set by a write pulse, cleared by one.
// Assumes set and clear never target the same bit in the same cycle; if
// they do, set wins.
module stt_wstat #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] ack_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic ack_q;

        // One sticky acknowledge flag.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)       ack_q <= 1'b0;
            else if (set_i[i]) ack_q <= 1'b1;
            else if (clr_i[i]) ack_q <= 1'b0;
        end

        assign ack_o[i] = ack_q;
    end

endmodule

// File: rtl/sys_tick_timer.sv
// System tick timer top: register file, counter, comparator, interrupt
// and write acknowledges. Assumes one clock domain and single-cycle
// register writes; reads are combinational on the address.
module sys_tick_timer
    import stt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam int CNT_W = 2 * DATA_W;

    reg_id_e           rid;
    logic              wen;
    logic              ctl_run_q;
    logic              ctl_auto_q;
    logic              ctl_cmpen_q;
    logic              ien_q;
    logic [CNT_W-1:0]  count_w;
    logic [CNT_W-1:0]  cmp_w;
    logic [DATA_W-1:0] step_w;
    logic              istat_w;
    logic [CWS_N-1:0]  cws_set;
    logic [CWS_N-1:0]  cws_clr;
    logic [CWS_N-1:0]  cws_w;
    logic [GWS_N-1:0]  gws_set;
    logic [GWS_N-1:0]  gws_clr;
    logic [GWS_N-1:0]  gws_w;

    assign wen = bus_sel_i && bus_wr_i;

    stt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .rid_o  (rid)
    );

    // Control and interrupt-enable registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_run_q   <= 1'b0;
            ctl_auto_q  <= 1'b0;
            ctl_cmpen_q <= 1'b0;
            ien_q       <= 1'b0;
        end else if (wen) begin
            if (rid == RID_CTRL) begin
                ctl_run_q   <= bus_wdata_i[CTL_RUN_BIT];
                ctl_auto_q  <= bus_wdata_i[CTL_AUTO_BIT];
                ctl_cmpen_q <= bus_wdata_i[CTL_CMPEN_BIT];
            end
            if (rid == RID_IEN) ien_q <= bus_wdata_i[0];
        end
    end

    stt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (ctl_run_q),
        .wr_lo_i (wen && rid == RID_CNT_LO),
        .wr_hi_i (wen && rid == RID_CNT_HI),
        .wdata_i (bus_wdata_i),
        .count_o (count_w)
    );

    stt_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (ctl_cmpen_q),
        .auto_i    (ctl_auto_q),
        .count_i   (count_w),
        .wr_lo_i   (wen && rid == RID_CMP_LO),
        .wr_hi_i   (wen && rid == RID_CMP_HI),
        .wr_step_i (wen && rid == RID_STEP),
        .clr_i     (wen && rid == RID_ISTAT && bus_wdata_i[0]),
        .wdata_i   (bus_wdata_i),
        .cmp_o     (cmp_w),
        .step_o    (step_w),
        .stat_o    (istat_w)
    );

    // Acknowledge set pulses, in acknowledge-index order.
    assign cws_set = {wen && rid == RID_CNT_HI, wen && rid == RID_CNT_LO};
    assign gws_set = {wen && rid == RID_CTRL,   wen && rid == RID_STEP,
                      wen && rid == RID_CMP_HI, wen && rid == RID_CMP_LO};

    for (genvar i = 0; i < CWS_N; i++) begin : g_cws_clr
        assign cws_clr[i] = wen && rid == RID_CNT_WS && bus_wdata_i[i];
    end

    for (genvar i = 0; i < GWS_N; i++) begin : g_gws_clr
        assign gws_clr[i] = wen && rid == RID_GWS && bus_wdata_i[gws_pos(i)];
    end

    stt_wstat #(.N(CWS_N)) u_cws (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (cws_set),
        .clr_i  (cws_clr),
        .ack_o  (cws_w)
    );

    stt_wstat #(.N(GWS_N)) u_gws (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (gws_set),
        .clr_i  (gws_clr),
        .ack_o  (gws_w)
    );

    // Read data selection.
    always_comb begin
        bus_rdata_o = '0;
        case (rid)
            RID_CNT_LO: bus_rdata_o = count_w[DATA_W-1:0];
            RID_CNT_HI: bus_rdata_o = count_w[CNT_W-1:DATA_W];
            RID_CNT_WS: bus_rdata_o[CWS_N-1:0] = cws_w;
            RID_CMP_LO: bus_rdata_o = cmp_w[DATA_W-1:0];
            RID_CMP_HI: bus_rdata_o = cmp_w[CNT_W-1:DATA_W];
            RID_STEP:   bus_rdata_o = step_w;
            RID_CTRL: begin
                bus_rdata_o[CTL_RUN_BIT]   = ctl_run_q;
                bus_rdata_o[CTL_AUTO_BIT]  = ctl_auto_q;
                bus_rdata_o[CTL_CMPEN_BIT] = ctl_cmpen_q;
            end
            RID_ISTAT:  bus_rdata_o[0] = istat_w;
            RID_IEN:    bus_rdata_o[0] = ien_q;
            RID_GWS: begin
                for (int i = 0; i < GWS_N; i++) bus_rdata_o[gws_pos(i)] = gws_w[i];
            end
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_o = istat_w && ien_q;

endmodule

// File: rtl/sys_tick_timer_chk.sv
// Property checker for sys_tick_timer, attached by bind.
// Assumes the same parameters as the bound top.
module sys_tick_timer_chk
    import stt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bus_sel_i,
    input logic                bus_wr_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [DATA_W-1:0]   bus_wdata_i,
    input logic                irq_o,
    input logic [2*DATA_W-1:0] count_w,
    input logic [2*DATA_W-1:0] cmp_w,
    input logic [DATA_W-1:0]   step_w,
    input logic                ctl_run_q,
    input logic                ctl_auto_q,
    input logic                ctl_cmpen_q,
    input logic                istat_w,
    input logic                ien_q,
    input logic [GWS_N-1:0]    gws_w
);

    localparam int CNT_W = 2 * DATA_W;

    logic wen, cnt_wr, cmp_wr, ctrl_wr, clr_wr, gws3_clr, hit;

    assign wen      = bus_sel_i && bus_wr_i;
    assign cnt_wr   = wen && (bus_addr_i == ADDR_W'(OFS_CNT_LO) || bus_addr_i == ADDR_W'(OFS_CNT_HI));
    assign cmp_wr   = wen && (bus_addr_i == ADDR_W'(OFS_CMP_LO) || bus_addr_i == ADDR_W'(OFS_CMP_HI));
    assign ctrl_wr  = wen && bus_addr_i == ADDR_W'(OFS_CTRL);
    assign clr_wr   = wen && bus_addr_i == ADDR_W'(OFS_ISTAT) && bus_wdata_i[0];
    assign gws3_clr = wen && bus_addr_i == ADDR_W'(OFS_GWS) && bus_wdata_i[16];
    assign hit      = ctl_cmpen_q && (count_w == cmp_w);

    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_run_q && !cnt_wr) |=> (count_w == $past(count_w) + CNT_W'(1)));

    p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctl_run_q && !cnt_wr) |=> $stable(count_w));

    p_match_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> istat_w);

    p_auto_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && ctl_auto_q && !cmp_wr) |=> (cmp_w == $past(cmp_w) + CNT_W'($past(step_w))));

    p_stat_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && !hit) |=> !istat_w);

    p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (istat_w && ien_q));

    p_ctrl_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr |=> gws_w[3]);

    p_ack_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gws_w[3] && !gws3_clr) |=> gws_w[3]);

endmodule

bind sys_tick_timer sys_tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .count_w     (count_w),
    .cmp_w       (cmp_w),
    .step_w      (step_w),
    .ctl_run_q   (ctl_run_q),
    .ctl_auto_q  (ctl_auto_q),
    .ctl_cmpen_q (ctl_cmpen_q),
    .istat_w     (istat_w),
    .ien_q       (ien_q),
    .gws_w       (gws_w)
);

// File: tb/sys_tick_timer_tb_top.sv
// Directed bench for sys_tick_timer: one task per scenario.
`timescale 1ns/100ps
module sys_tick_timer_tb_top;

    localparam logic [11:0] A_CLO = 12'h100, A_CHI = 12'h104, A_CWS = 12'h110;
    localparam logic [11:0] A_MLO = 12'h200, A_MHI = 12'h204, A_STP = 12'h208;
    localparam logic [11:0] A_CTL = 12'h240, A_IST = 12'h244, A_IEN = 12'h248;
    localparam logic [11:0] A_GWS = 12'h24C, A_BAD = 12'h300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    sys_tick_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Called just after a falling edge; write lands on the next rising edge.
    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(A_CLO, v); chk("R1 count low", v, 0);
        rreg(A_CTL, v); chk("R1 control", v, 0);
        rreg(A_IST, v); chk("R1 istat", v, 0);
        waitc(1);
        rreg(A_GWS, v); chk("R1 gws", v, 0);
        rreg(A_CWS, v); chk("R1 cws", v, 0);
        rreg(A_IEN, v); chk("R1 ien", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_count_run();
        logic [31:0] v;
        wreg(A_CLO, 0); wreg(A_CHI, 0);
        wreg(A_CTL, 32'h100);
        rreg(A_CLO, v); chk("R2 start", v, 0);
        waitc(7);
        rreg(A_CLO, v); chk("R2 after 7", v, 7);
        wreg(A_CTL, 0);
        rreg(A_CLO, v); chk("R2 stop value", v, 8);
        waitc(4);
        rreg(A_CLO, v); chk("R2 held", v, 8);
    endtask

    task automatic t_preload();
        logic [31:0] v;
        wreg(A_CLO, 32'hFFFF_FFFE); wreg(A_CHI, 5);
        wreg(A_CTL, 32'h100);
        waitc(3);
        rreg(A_CLO, v); chk("R3 carry low", v, 1);
        rreg(A_CHI, v); chk("R3 carry high", v, 6);
        wreg(A_CLO, 32'h10);
        rreg(A_CLO, v); chk("R3 write over increment", v, 32'h10);
        rreg(A_CHI, v); chk("R3 high kept", v, 6);
        wreg(A_CTL, 0);
    endtask

    task automatic t_wstat();
        logic [31:0] v;
        wreg(A_GWS, 32'h0001_0007); wreg(A_CWS, 3);
        rreg(A_GWS, v); chk("R9 gws cleared", v, 0);
        rreg(A_CWS, v); chk("R9 cws cleared", v, 0);
        wreg(A_STP, 9);
        rreg(A_GWS, v); chk("R8 step ack", v, 32'h4);
        wreg(A_CTL, 0);
        rreg(A_GWS, v); chk("R8 ctrl ack", v, 32'h0001_0004);
        wreg(A_GWS, 0);
        rreg(A_GWS, v); chk("R9 zero write", v, 32'h0001_0004);
        wreg(A_GWS, 32'h4);
        rreg(A_GWS, v); chk("R9 single clear", v, 32'h0001_0000);
        wreg(A_CLO, 0);
        rreg(A_CWS, v); chk("R8 count low ack", v, 1);
        wreg(A_CHI, 0);
        rreg(A_CWS, v); chk("R8 count high ack", v, 3);
        wreg(A_CWS, 1);
        rreg(A_CWS, v); chk("R9 cws partial clear", v, 2);
        wreg(A_MLO, 0); wreg(A_MHI, 0);
        rreg(A_GWS, v); chk("R8 compare acks", v, 32'h0001_0003);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wreg(A_CTL, 32'hFFFF_FFFF);
        rreg(A_CTL, v); chk("R10 ctrl mask", v, 32'h103);
        wreg(A_CTL, 0);
        wreg(A_BAD, 32'hFFFF_FFFF);
        rreg(A_BAD, v); chk("R10 unmapped read", v, 0);
        rreg(A_CTL, v); chk("R10 ctrl untouched", v, 0);
        rreg(A_IEN, v); chk("R10 ien untouched", v, 0);
    endtask

    task automatic t_compare();
        logic [31:0] v;
        wreg(A_IST, 1); wreg(A_IEN, 1);
        wreg(A_CLO, 0); wreg(A_CHI, 0); wreg(A_MLO, 20); wreg(A_MHI, 0);
        chk("R7 irq idle", {31'b0, irq}, 0);
        wreg(A_CTL, 32'h101);
        waitc(20);
        rreg(A_IST, v); chk("R4 no status before edge", v, 0);
        waitc(1);
        rreg(A_IST, v); chk("R4 status on match", v, 1);
        chk("R7 irq raised", {31'b0, irq}, 1);
        rreg(A_MLO, v); chk("R5 no auto keeps compare", v, 20);
        wreg(A_CTL, 0); wreg(A_IST, 1);
    endtask

    task automatic t_compare_off();
        logic [31:0] v;
        wreg(A_CLO, 0); wreg(A_CHI, 0); wreg(A_MLO, 3);
        wreg(A_CTL, 32'h100);
        waitc(6);
        rreg(A_IST, v); chk("R4 disabled compare", v, 0);
        wreg(A_CTL, 0);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        wreg(A_CLO, 0); wreg(A_CHI, 0); wreg(A_MLO, 10); wreg(A_MHI, 0);
        wreg(A_STP, 7); wreg(A_IST, 1);
        wreg(A_CTL, 32'h103);
        waitc(11);
        rreg(A_IST, v); chk("R5 first match", v, 1);
        rreg(A_MLO, v); chk("R5 compare advanced", v, 17);
        wreg(A_IST, 1);
        rreg(A_IST, v); chk("R6 cleared", v, 0);
        waitc(5);
        rreg(A_IST, v); chk("R5 not yet second", v, 0);
        waitc(1);
        rreg(A_IST, v); chk("R5 second match", v, 1);
        rreg(A_MLO, v); chk("R5 compare advanced again", v, 24);
        wreg(A_CTL, 0); wreg(A_IST, 1);
    endtask

    task automatic t_stat_clear();
        logic [31:0] v;
        wreg(A_CLO, 50); wreg(A_CHI, 0); wreg(A_MLO, 50); wreg(A_MHI, 0);
        wreg(A_CTL, 32'h1);
        waitc(1);
        rreg(A_IST, v); chk("R4 stopped match", v, 1);
        wreg(A_IST, 1);
        rreg(A_IST, v); chk("R6 match wins over clear", v, 1);
        wreg(A_CTL, 0);
        wreg(A_IST, 0);
        rreg(A_IST, v); chk("R6 zero write", v, 1);
        wreg(A_IST, 1);
        rreg(A_IST, v); chk("R6 clear", v, 0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] v;
        wreg(A_IEN, 0);
        wreg(A_CTL, 32'h1);
        wreg(A_CTL, 0);
        rreg(A_IST, v); chk("R7 status set", v, 1);
        chk("R7 irq masked", {31'b0, irq}, 0);
        wreg(A_IEN, 1);
        rreg(A_IEN, v); chk("R7 ien readback", v, 1);
        chk("R7 irq unmasked", {31'b0, irq}, 1);
        wreg(A_IST, 1);
        chk("R7 irq after clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_run();
        t_preload();
        t_wstat();
        t_ctrl_mask();
        t_compare();
        t_compare_off();
        t_auto();
        t_stat_clear();
        t_irq_gate();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule